// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block executes the seven classic byte/word/dword string operations (block move, block compare, store, load, scan, port input, port output) one element at a time. A caller latches the operation, the element size, the direction, the repeat mode and the working registers (count, source index, destination index, accumulator), together with the source and destination segment bases, by pulsing `start`. The sequencer then issues each element's reads and writes on a memory port and an I/O port. Both ports use a request/acknowledge handshake. It commits the updated count and index registers after each element.

A repeated run is cut into bounded bursts. A burst stops when the count runs out or when a compare disagrees with the repeat polarity. It also stops when an iteration budget is spent or when, with paging enabled, a 4 KiB page edge of a used address is reached. When a burst stops early, `restart` is raised alongside `done`, so the surrounding core can take interrupts and then re-issue the instruction. Compare operations return the last compared pair. The flags are formed outside the block as source minus destination.

Top module: `strop_seq`

## Requirements
- R1: `op_sel` selects the operation and thereby which indices and ports an element uses: 0 move (read at source, write at destination), 1 compare (read source, read destination), 2 store (write accumulator at destination), 3 load (read source into accumulator), 4 scan (read destination, compare with accumulator), 5 port input (I/O read, then memory write at destination), 6 port output (memory read at source, then I/O write).
- R2: `elem_size` 0, 1 and 2 give 1, 2 and 4 byte elements (3 acts as 4). After each element, every used index moves by plus the size when `dir_dn` is 0 and by minus the size when `dir_dn` is 1.
- R3: When `rep_mode` is 1 or 2 and the count is zero, the invocation makes no memory or I/O access, changes no register and ends with `done` and `restart` low.
- R4: In a repeated run (`rep_mode` 1 or 2), every element decrements the count, and the run ends when the count reaches zero.
- R5: For compare and scan, `rep_mode` 1 (repeat-while-equal) also ends the run on a mismatch, and `rep_mode` 2 (repeat-while-unequal) also ends it on a match. This check takes priority over the budget stop.
- R6: With `rep_mode` 0 (or 3), exactly one element is processed, the used indices advance, and the count is unchanged.
- R7: After a compare or scan, `cmp_valid` is high together with `done`, and `cmp_src` and `cmp_dst` carry the last compared pair masked to the element size. For scan, `cmp_src` is the accumulator, not a memory value.
- R8: One invocation processes at most `MAX_BURST` elements. If a repeated run is still unfinished at that point, `restart` is high with `done`.
- R9: With `paging_en` set, a burst also stops at the 4 KiB page edge of the source or destination address, whichever comes first. The remaining element count is derived from the low 12 address bits and the direction, and an unfinished run then raises `restart`.
- R10: The destination address is `dst_base` plus the destination index, and the source address is `src_base` plus the source index.
- R11: A request stays high with a stable address until it is acknowledged. The memory and I/O requests are never high together, and the next element starts only after the current element's accesses complete.
- R12: After reset the block is idle with no request pending. `done` is a single-cycle pulse at the end of every invocation.
- R13: Load merges the read value into the low bytes of the accumulator and keeps its upper bytes. Port transfers use `port_in` as the I/O address and carry the element value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch operands and begin an invocation (ignored while busy) |
| op_sel | input | 3 | Operation code (R1) |
| elem_size | input | 2 | Element size code (R2) |
| dir_dn | input | 1 | 1 = indices step downward |
| rep_mode | input | 2 | 0 none, 1 repeat-while-equal, 2 repeat-while-unequal |
| paging_en | input | 1 | Enable page-edge burst limit |
| cnt_in | input | AW | Count register |
| src_idx_in | input | AW | Source index |
| dst_idx_in | input | AW | Destination index |
| acc_in | input | 32 | Accumulator |
| src_base | input | AW | Source segment base |
| dst_base | input | AW | Destination segment base |
| port_in | input | PW | I/O port address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |
| io_req | output | 1 | I/O request |
| io_we | output | 1 | I/O write enable |
| io_addr | output | PW | I/O port address |
| io_size | output | 2 | I/O size code |
| io_wdata | output | 32 | I/O write data |
| io_rdata | input | 32 | I/O read data, valid with ack |
| io_ack | input | 1 | I/O acknowledge |
| busy | output | 1 | Invocation in progress |
| done | output | 1 | End-of-invocation pulse |
| restart | output | 1 | Burst stopped early, re-issue instruction |
| cnt_out | output | AW | Count register after the run |
| si_out | output | AW | Source index after the run |
| di_out | output | AW | Destination index after the run |
| acc_out | output | 32 | Accumulator after the run |
| cmp_valid | output | 1 | Compare pair valid (with done) |
| cmp_src | output | 32 | Last compare source value |
| cmp_dst | output | 32 | Last compare destination value |

## Verification
The assertions assume that the memory and I/O responders raise an acknowledge only while the matching request is high, and only for one cycle at a time. They also assume that `start` arrives only while the block is idle and that addresses are aligned to the element size. The bench responders acknowledge exactly one cycle after an unacknowledged request. Every vector begins from idle with aligned indices and zero or small segment bases, and the page-edge cases approach the boundary from aligned offsets in both directions.

// File: rtl/strop_pkg.sv
package strop_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_CMP   = 3'd1,
        OP_STORE = 3'd2,
        OP_LOAD  = 3'd3,
        OP_SCAN  = 3'd4,
        OP_PIN   = 3'd5,
        OP_POUT  = 3'd6,
        OP_RSVD  = 3'd7
    } str_op_e;

    typedef enum logic [1:0] {
        RPT_NONE = 2'd0,
        RPT_EQ   = 2'd1,
        RPT_NE   = 2'd2,
        RPT_XX   = 2'd3
    } rpt_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ARM, S_RD_SRC, S_RD_DST, S_IO_RD, S_WR_MEM, S_IO_WR, S_STEP, S_FIN
    } seq_state_e;

    typedef struct packed {
        logic rd_src;
        logic rd_dst;
        logic wr_mem;
        logic cmp;
        logic io_in;
        logic io_out;
    } op_use_t;

    function automatic op_use_t decode_op(str_op_e op);
        op_use_t u;
        u = '0;
        case (op)
            OP_MOVE:  begin u.rd_src = 1'b1; u.wr_mem = 1'b1; end
            OP_CMP:   begin u.rd_src = 1'b1; u.rd_dst = 1'b1; u.cmp = 1'b1; end
            OP_STORE: u.wr_mem = 1'b1;
            OP_LOAD:  u.rd_src = 1'b1;
            OP_SCAN:  begin u.rd_dst = 1'b1; u.cmp = 1'b1; end
            OP_PIN:   begin u.io_in = 1'b1; u.wr_mem = 1'b1; end
            OP_POUT:  begin u.rd_src = 1'b1; u.io_out = 1'b1; end
            default:  u.wr_mem = 1'b0;
        endcase
        return u;
    endfunction

    function automatic logic [2:0] size_bytes(logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] size_shift(logic [1:0] sz);
        case (sz)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/strop_stride.sv
module strop_stride
    import strop_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] src_idx,
    input  logic [AW-1:0] dst_idx,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [1:0]    sz,
    input  logic          dn,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [AW-1:0] src_idx_nx,
    output logic [AW-1:0] dst_idx_nx
);
    logic [AW-1:0] stride;

    assign stride     = dn ? (AW'(0) - AW'(size_bytes(sz))) : AW'(size_bytes(sz));
    assign src_addr   = src_base + src_idx;
    assign dst_addr   = dst_base + dst_idx;
    assign src_idx_nx = src_idx + stride;
    assign dst_idx_nx = dst_idx + stride;
endmodule

// File: rtl/strop_budget.sv
module strop_budget
    import strop_pkg::*;
#(
    parameter int MAX_BURST = 16384,
    parameter int BW        = $clog2(MAX_BURST + 1)
) (
    input  logic [11:0]   src_low,
    input  logic [11:0]   dst_low,
    input  logic          use_src,
    input  logic          use_dst,
    input  logic [1:0]    sz,
    input  logic          dn,
    input  logic          paging,
    output logic [BW-1:0] limit
);
    logic [31:0] lim;
    logic [31:0] src_left;
    logic [31:0] dst_left;

    function automatic logic [31:0] page_left(logic [11:0] low, logic down, logic [1:0] sh);
        if (down) return ({20'd0, low} >> sh) + 32'd1;
        return (32'd4096 - {20'd0, low}) >> sh;
    endfunction

    assign src_left = page_left(src_low, dn, size_shift(sz));
    assign dst_left = page_left(dst_low, dn, size_shift(sz));

    always_comb begin
        lim = 32'(MAX_BURST);
        if (paging && use_src && src_left < lim) lim = src_left;
        if (paging && use_dst && dst_left < lim) lim = dst_left;
        limit = BW'(lim);
    end
endmodule

// File: rtl/strop_seq.sv
module strop_seq
    import strop_pkg::*;
#(
    parameter int AW        = 32,
    parameter int PW        = 16,
    parameter int MAX_BURST = 16384
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    op_sel,
    input  logic [1:0]    elem_size,
    input  logic          dir_dn,
    input  logic [1:0]    rep_mode,
    input  logic          paging_en,
    input  logic [AW-1:0] cnt_in,
    input  logic [AW-1:0] src_idx_in,
    input  logic [AW-1:0] dst_idx_in,
    input  logic [31:0]   acc_in,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [PW-1:0] port_in,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    output logic          io_req,
    output logic          io_we,
    output logic [PW-1:0] io_addr,
    output logic [1:0]    io_size,
    output logic [31:0]   io_wdata,
    input  logic [31:0]   io_rdata,
    input  logic          io_ack,
    output logic          busy,
    output logic          done,
    output logic          restart,
    output logic [AW-1:0] cnt_out,
    output logic [AW-1:0] si_out,
    output logic [AW-1:0] di_out,
    output logic [31:0]   acc_out,
    output logic          cmp_valid,
    output logic [31:0]   cmp_src,
    output logic [31:0]   cmp_dst
);
    localparam int BW = $clog2(MAX_BURST + 1);

    seq_state_e    st;
    str_op_e       op_r;
    rpt_e          rep_r;
    logic [1:0]    sz_r;
    logic          dn_r, pg_r;
    logic [AW-1:0] cnt_r, cnt0_r, si_r, di_r, sb_r, db_r;
    logic [31:0]   acc_r, xfer_r, cs_r, cd_r;
    logic [PW-1:0] port_r;
    logic [BW-1:0] budget_r, limit;
    logic          did_cmp_r, restart_r;

    op_use_t       use_op;
    logic          use_dst, cmp_eq;
    logic [31:0]   mask;
    seq_state_e    first_st, after_src;
    logic [AW-1:0] src_addr, dst_addr, si_nx, di_nx;

    assign use_op  = decode_op(op_r);
    assign use_dst = use_op.rd_dst | use_op.wr_mem;
    assign mask    = size_mask(sz_r);
    assign cmp_eq  = (cs_r == cd_r);

    always_comb begin
        if (use_op.rd_src)     first_st = S_RD_SRC;
        else if (use_op.io_in) first_st = S_IO_RD;
        else if (use_op.rd_dst) first_st = S_RD_DST;
        else                   first_st = S_WR_MEM;
        if (use_op.rd_dst)      after_src = S_RD_DST;
        else if (use_op.wr_mem) after_src = S_WR_MEM;
        else if (use_op.io_out) after_src = S_IO_WR;
        else                    after_src = S_STEP;
    end

    strop_stride #(.AW(AW)) u_stride (
        .src_idx(si_r), .dst_idx(di_r), .src_base(sb_r), .dst_base(db_r),
        .sz(sz_r), .dn(dn_r),
        .src_addr(src_addr), .dst_addr(dst_addr), .src_idx_nx(si_nx), .dst_idx_nx(di_nx)
    );

    strop_budget #(.MAX_BURST(MAX_BURST), .BW(BW)) u_budget (
        .src_low(src_addr[11:0]), .dst_low(dst_addr[11:0]),
        .use_src(use_op.rd_src), .use_dst(use_dst),
        .sz(sz_r), .dn(dn_r), .paging(pg_r), .limit(limit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; op_r <= OP_MOVE; rep_r <= RPT_NONE; sz_r <= '0;
            dn_r <= 1'b0; pg_r <= 1'b0; cnt_r <= '0; cnt0_r <= '0;
            si_r <= '0; di_r <= '0; sb_r <= '0; db_r <= '0; acc_r <= '0;
            xfer_r <= '0; cs_r <= '0; cd_r <= '0; port_r <= '0;
            budget_r <= '0; did_cmp_r <= 1'b0; restart_r <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    op_r  <= str_op_e'(op_sel);
                    rep_r <= (rep_mode == 2'd3) ? RPT_NONE : rpt_e'(rep_mode);
                    sz_r <= elem_size; dn_r <= dir_dn; pg_r <= paging_en;
                    cnt_r <= cnt_in; cnt0_r <= cnt_in;
                    si_r <= src_idx_in; di_r <= dst_idx_in; acc_r <= acc_in;
                    sb_r <= src_base; db_r <= dst_base; port_r <= port_in;
                    did_cmp_r <= 1'b0; restart_r <= 1'b0;
                    st <= S_ARM;
                end
                S_ARM: begin
                    budget_r <= limit;
                    if (rep_r != RPT_NONE && cnt_r == '0) st <= S_FIN;
                    else                                  st <= first_st;
                end
                S_RD_SRC: if (mem_ack) begin
                    xfer_r <= mem_rdata & mask;
                    if (use_op.cmp) cs_r <= mem_rdata & mask;
                    if (op_r == OP_LOAD) acc_r <= (acc_r & ~mask) | (mem_rdata & mask);
                    st <= after_src;
                end
                S_RD_DST: if (mem_ack) begin
                    cd_r <= mem_rdata & mask;
                    if (op_r == OP_SCAN) cs_r <= acc_r & mask;
                    did_cmp_r <= 1'b1;
                    st <= S_STEP;
                end
                S_IO_RD: if (io_ack) begin
                    xfer_r <= io_rdata & mask;
                    st <= S_WR_MEM;
                end
                S_WR_MEM: if (mem_ack) st <= S_STEP;
                S_IO_WR:  if (io_ack)  st <= S_STEP;
                S_STEP: begin
                    if (use_op.rd_src) si_r <= si_nx;
                    if (use_dst)       di_r <= di_nx;
                    if (rep_r == RPT_NONE) begin
                        st <= S_FIN;
                    end else begin
                        cnt_r    <= cnt_r - AW'(1);
                        budget_r <= budget_r - BW'(1);
                        if (cnt_r == AW'(1))                              st <= S_FIN;
                        else if (use_op.cmp && (cmp_eq != (rep_r == RPT_EQ))) st <= S_FIN;
                        else if (budget_r == BW'(1)) begin
                            restart_r <= 1'b1;
                            st        <= S_FIN;
                        end else st <= first_st;
                    end
                end
                S_FIN:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign mem_req   = (st == S_RD_SRC) || (st == S_RD_DST) || (st == S_WR_MEM);
    assign mem_we    = (st == S_WR_MEM);
    assign mem_addr  = (st == S_RD_SRC) ? src_addr : dst_addr;
    assign mem_size  = sz_r;
    assign mem_wdata = ((op_r == OP_STORE) ? acc_r : xfer_r) & mask;
    assign io_req    = (st == S_IO_RD) || (st == S_IO_WR);
    assign io_we     = (st == S_IO_WR);
    assign io_addr   = port_r;
    assign io_size   = sz_r;
    assign io_wdata  = xfer_r;
    assign busy      = (st != S_IDLE);
    assign done      = (st == S_FIN);
    assign restart   = restart_r;
    assign cnt_out   = cnt_r;
    assign si_out    = si_r;
    assign di_out    = di_r;
    assign acc_out   = acc_r;
    assign cmp_valid = done && did_cmp_r;
    assign cmp_src   = cs_r;
    assign cmp_dst   = cd_r;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
    AST_IO_HOLD: assert property (@(posedge clk) disable iff (rst)
        io_req && !io_ack |=> io_req && $stable(io_we)); // R11
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && io_req)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12
    AST_RESTART_REP: assert property (@(posedge clk) disable iff (rst)
        done && restart |-> rep_r != RPT_NONE && cnt_r != '0); // R8
    AST_SINGLE_CNT: assert property (@(posedge clk) disable iff (rst)
        done && rep_r == RPT_NONE |-> cnt_r == cnt0_r && !restart); // R6
endmodule

// File: tb/sim_strop_seq.sv
module sim_strop_seq;
    localparam int MB = 8;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic        dn;
        logic [1:0]  rp;
        logic        pg;
        logic [15:0] cnt;
        logic [15:0] si;
        logic [15:0] di;
        logic [31:0] acc;
        logic [15:0] poke;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 1'b0, 2'd1, 1'b0, 16'd5,   16'h0100, 16'h0400, 32'h0,        16'h0},
        '{3'd0, 2'd1, 1'b1, 2'd1, 1'b0, 16'd3,   16'h0140, 16'h0480, 32'h0,        16'h0},
        '{3'd0, 2'd2, 1'b0, 2'd1, 1'b1, 16'd100, 16'h0FF0, 16'h1800, 32'h0,        16'h0},
        '{3'd1, 2'd0, 1'b0, 2'd1, 1'b0, 16'd6,   16'h0100, 16'h0200, 32'h0,        16'h0203},
        '{3'd1, 2'd1, 1'b0, 2'd2, 1'b0, 16'd5,   16'h0100, 16'h0300, 32'h0,        16'h0},
        '{3'd2, 2'd2, 1'b0, 2'd1, 1'b0, 16'd4,   16'h0000, 16'h0500, 32'hDEADBEEF, 16'h0},
        '{3'd2, 2'd1, 1'b1, 2'd2, 1'b1, 16'd10,  16'h0000, 16'h1006, 32'h0000CAFE, 16'h0},
        '{3'd3, 2'd0, 1'b0, 2'd1, 1'b0, 16'd20,  16'h0000, 16'h0000, 32'h12345678, 16'h0},
        '{3'd4, 2'd0, 1'b0, 2'd2, 1'b0, 16'd20,  16'h0000, 16'h0300, 32'h00000007, 16'h0},
        '{3'd4, 2'd1, 1'b0, 2'd1, 1'b0, 16'd10,  16'h0000, 16'h0300, 32'h00000100, 16'h0},
        '{3'd5, 2'd1, 1'b0, 2'd1, 1'b0, 16'd3,   16'h0000, 16'h0600, 32'h0,        16'h0},
        '{3'd6, 2'd2, 1'b1, 2'd0, 1'b0, 16'd7,   16'h0108, 16'h0000, 32'h0,        16'h0},
        '{3'd0, 2'd0, 1'b0, 2'd1, 1'b0, 16'd0,   16'h0100, 16'h0400, 32'h0,        16'h0},
        '{3'd1, 2'd2, 1'b0, 2'd0, 1'b0, 16'd9,   16'h0104, 16'h0208, 32'h0,        16'h0},
        '{3'd1, 2'd0, 1'b1, 2'd1, 1'b1, 16'd3,   16'h1001, 16'h0201, 32'h0,        16'h0}
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [2:0] op_sel = '0; logic [1:0] elem_size = '0, rep_mode = '0;
    logic dir_dn = 1'b0, paging_en = 1'b0;
    logic [31:0] cnt_in = '0, src_idx_in = '0, dst_idx_in = '0, acc_in = '0;
    logic [31:0] src_base = '0, dst_base = '0;
    logic [15:0] port_in = 16'h03F8;
    logic mem_req, mem_we, io_req, io_we, busy, done, restart, cmp_valid;
    logic [31:0] mem_addr, mem_wdata, io_wdata, cnt_out, si_out, di_out, acc_out, cmp_src, cmp_dst;
    logic [1:0] mem_size, io_size;
    logic [15:0] io_addr;
    logic [31:0] mem_rdata = '0, io_rdata = '0;
    logic mem_ack = 1'b0, io_ack = 1'b0;

    always #4 clk = ~clk;

    strop_seq #(.AW(32), .PW(16), .MAX_BURST(MB)) u0 (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .elem_size(elem_size),
        .dir_dn(dir_dn), .rep_mode(rep_mode), .paging_en(paging_en),
        .cnt_in(cnt_in), .src_idx_in(src_idx_in), .dst_idx_in(dst_idx_in), .acc_in(acc_in),
        .src_base(src_base), .dst_base(dst_base), .port_in(port_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_size(io_size),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack),
        .busy(busy), .done(done), .restart(restart), .cnt_out(cnt_out),
        .si_out(si_out), .di_out(di_out), .acc_out(acc_out),
        .cmp_valid(cmp_valid), .cmp_src(cmp_src), .cmp_dst(cmp_dst)
    );

    logic [7:0] mem [0:8191];
    int n_mem = 0, n_io = 0, n_iord = 0;
    logic [31:0] io_last = '0;
    logic [15:0] io_seen = '0;
    int checks = 0, errors = 0;

    function automatic logic [31:0] bytes_of(logic [1:0] sz);
        return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    endfunction
    function automatic logic [31:0] mask_of(logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction
    function automatic logic [31:0] rd(logic [31:0] a, logic [1:0] sz);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) v[8*k +: 8] = mem[(a + k) & 32'h1FFF];
        return v & mask_of(sz);
    endfunction

    always @(posedge clk) begin
        if (rst) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            n_mem   <= n_mem + 1;
            if (mem_we) begin
                for (int k = 0; k < 4; k++)
                    if (k < int'(bytes_of(mem_size))) mem[(mem_addr + k) & 32'h1FFF] <= mem_wdata[8*k +: 8];
            end else mem_rdata <= rd(mem_addr, 2'd2);
        end else mem_ack <= 1'b0;
    end

    always @(posedge clk) begin
        if (rst) io_ack <= 1'b0;
        else if (io_req && !io_ack) begin
            io_ack  <= 1'b1;
            n_io    <= n_io + 1;
            io_seen <= io_addr;
            if (io_we) io_last <= io_wdata;
            else begin
                io_rdata <= 32'h8800_0000 + n_iord;
                n_iord   <= n_iord + 1;
            end
        end else io_ack <= 1'b0;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 8192; i++) mem[i] = i[7:0];
    endtask

    logic [31:0] got_cs, got_cd;
    logic got_cv;

    task automatic run(input logic [2:0] op, input logic [1:0] sz, input logic dn,
                       input logic [1:0] rp, input logic pg, input logic [31:0] cnt,
                       input logic [31:0] si, input logic [31:0] di, input logic [31:0] acc,
                       input logic [31:0] sb, input logic [31:0] db);
        int t;
        @(negedge clk);
        op_sel = op; elem_size = sz; dir_dn = dn; rep_mode = rp; paging_en = pg;
        cnt_in = cnt; src_idx_in = si; dst_idx_in = di; acc_in = acc;
        src_base = sb; dst_base = db;
        n_mem = 0; n_io = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 5000) begin @(negedge clk); t++; end
        chk("R12", "done seen", {31'd0, done}, 32'd1);
        got_cv = cmp_valid; got_cs = cmp_src; got_cd = cmp_dst;
        @(negedge clk);
        chk("R12", "done one cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        init_mem();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "reset busy", {31'd0, busy}, 32'd0);
        chk("R12", "reset done", {31'd0, done}, 32'd0);
        chk("R12", "reset mem_req", {31'd0, mem_req}, 32'd0);
        chk("R12", "reset io_req", {31'd0, io_req}, 32'd0);
        chk("R12", "reset restart", {31'd0, restart}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            vec_t x;
            logic [31:0] c, s, d, a, m, b, cs, cd, lim, n, e_mem, e_io;
            logic rs, cv, usrc, udst, iscmp;
            x = VECS[v];
            init_mem();
            if (x.poke != 16'h0) mem[x.poke] = 8'hFF;
            m = mask_of(x.sz); b = bytes_of(x.sz);
            usrc  = (x.op == 3'd0) || (x.op == 3'd1) || (x.op == 3'd3) || (x.op == 3'd6);
            udst  = (x.op == 3'd0) || (x.op == 3'd1) || (x.op == 3'd2) || (x.op == 3'd4) || (x.op == 3'd5);
            iscmp = (x.op == 3'd1) || (x.op == 3'd4);
            c = {16'd0, x.cnt}; s = {16'd0, x.si}; d = {16'd0, x.di}; a = x.acc;
            cs = '0; cd = '0; rs = 1'b0; cv = 1'b0; n = 0;
            lim = MB;
            if (x.pg && usrc) begin
                logic [31:0] l;
                l = x.dn ? ((s & 32'hFFF) / b) + 1 : (32'h1000 - (s & 32'hFFF)) / b;
                if (l < lim) lim = l;
            end
            if (x.pg && udst) begin
                logic [31:0] l;
                l = x.dn ? ((d & 32'hFFF) / b) + 1 : (32'h1000 - (d & 32'hFFF)) / b;
                if (l < lim) lim = l;
            end
            if (!(x.rp != 2'd0 && c == 0)) begin
                for (int k = 0; k < 100000; k++) begin
                    if (iscmp) begin
                        cs = (x.op == 3'd4) ? (a & m) : rd(s, x.sz);
                        cd = rd(d, x.sz); cv = 1'b1;
                    end
                    if (x.op == 3'd3) a = (a & ~m) | rd(s, x.sz);
                    if (usrc) s = x.dn ? s - b : s + b;
                    if (udst) d = x.dn ? d - b : d + b;
                    n++;
                    if (x.rp == 2'd0) break;
                    c--;
                    if (c == 0) break;
                    if (iscmp && ((cs == cd) != (x.rp == 2'd1))) break;
                    if (n == lim) begin rs = 1'b1; break; end
                end
            end
            e_mem = n * (((x.op == 3'd0) || (x.op == 3'd1)) ? 32'd2 : 32'd1);
            e_io  = ((x.op == 3'd5) || (x.op == 3'd6)) ? n : 32'd0;
            run(x.op, x.sz, x.dn, x.rp, x.pg, {16'd0, x.cnt}, {16'd0, x.si}, {16'd0, x.di}, x.acc, 32'd0, 32'd0);
            chk("R4",  $sformatf("v%0d count", v), cnt_out, c);
            chk("R2",  $sformatf("v%0d src index", v), si_out, s);
            chk("R2",  $sformatf("v%0d dst index", v), di_out, d);
            chk("R13", $sformatf("v%0d accumulator", v), acc_out, a);
            chk("R8",  $sformatf("v%0d restart (R9 page edge)", v), {31'd0, restart}, {31'd0, rs});
            chk("R1",  $sformatf("v%0d memory accesses (R3 none on zero count)", v), n_mem, e_mem);
            chk("R1",  $sformatf("v%0d io accesses", v), n_io, e_io);
            chk("R7",  $sformatf("v%0d cmp_valid", v), {31'd0, got_cv}, {31'd0, cv});
            if (cv) begin
                chk("R5", $sformatf("v%0d cmp source", v), got_cs, cs);
                chk("R7", $sformatf("v%0d cmp destination", v), got_cd, cd);
            end
            if (x.rp == 2'd0) chk("R6", $sformatf("v%0d single count kept", v), cnt_out, {16'd0, x.cnt});
        end

        // R1: block move copies bytes
        init_mem();
        run(3'd0, 2'd0, 1'b0, 2'd1, 1'b0, 32'd4, 32'h120, 32'h700, 32'd0, 32'd0, 32'd0);
        for (int k = 0; k < 4; k++) chk("R1", "moved byte", {24'd0, mem[32'h700 + k]}, 32'h20 + k);
        chk("R4", "byte past run untouched", {24'd0, mem[32'h704]}, 32'h04);

        // R10: store uses destination base plus index
        init_mem();
        run(3'd2, 2'd0, 1'b0, 2'd0, 1'b0, 32'd9, 32'd0, 32'h10, 32'h11223344, 32'd0, 32'h40);
        chk("R10", "stored byte at base+index", {24'd0, mem[32'h50]}, 32'h44);
        chk("R10", "neighbour untouched", {24'd0, mem[32'h51]}, 32'h51);
        chk("R2",  "store index step", di_out, 32'h11);

        // R13 and R10: load merges into low half, source base applied
        init_mem();
        run(3'd3, 2'd1, 1'b0, 2'd0, 1'b0, 32'd1, 32'h10, 32'd0, 32'hAABBCCDD, 32'h200, 32'd0);
        chk("R13", "load merge", acc_out, 32'hAABB1110);
        chk("R2",  "load index step", si_out, 32'h12);

        // R13: port output value and port address
        init_mem();
        run(3'd6, 2'd1, 1'b0, 2'd0, 1'b0, 32'd1, 32'h30, 32'd0, 32'd0, 32'd0, 32'd0);
        chk("R13", "port write value", io_last, 32'h3130);
        chk("R13", "port address", {16'd0, io_seen}, 32'h03F8);

        // R3: zero count with repeat leaves indices and accumulator alone
        run(3'd4, 2'd2, 1'b1, 2'd2, 1'b0, 32'd0, 32'h44, 32'h88, 32'h5A5A5A5A, 32'd0, 32'd0);
        chk("R3", "zero count di", di_out, 32'h88);
        chk("R3", "zero count restart", {31'd0, restart}, 32'd0);
        chk("R3", "zero count accesses", n_mem, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule